// File: doc/BRIEF.md
# Rotating-Priority Request Arbiter

This block grants one of N requesters per cycle under round-robin priority. A registered pointer names the requester that holds top priority. The pointer is expanded into a thermometer mask that keeps only the requests at or above it. Two fixed-priority encoders run side by side, one on the masked requests and one on the raw requests. Each encoder picks its lowest-index set bit. The masked encoder wins whenever it finds anything. Otherwise the raw encoder supplies the grant, so the search wraps round to index 0.

The grant is combinational from the requests and the current pointer. On each clock edge the pointer moves to the index just past the winner, so the winner drops to lowest priority. There are no barrel shifters and no combinational feedback path. The pointer is kept in encoded form, log2(N) bits wide. N is a power of two from 8 to 64.

Top module: `rr_thermo_arbiter`

## Requirements
- R1: While reset is low the pointer is forced to index 0, so the first grant after reset goes to the lowest-index active request.
- R2: The grant vector has at most one bit set, and that bit always belongs to an active request; with no request the grant vector is all zero.
- R3: The any-grant output is high exactly when at least one request bit is high.
- R4: When some request has an index at or above the pointer, the grant goes to the lowest such index.
- R5: When no request sits at or above the pointer, the grant goes to the lowest-index active request.
- R6: After a clock edge with a grant at index g, the pointer holds (g+1) mod N, so a grant at index N-1 moves the pointer to 0.
- R7: A clock edge with no request leaves the pointer unchanged.
- R8: The grant and any-grant outputs follow a change of the request vector within the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pointer |
| reqVec | input | N | Request bits, one per requester |
| grantVec | output | N | One-hot grant, zero when idle |
| anyGrant | output | 1 | High when a grant is issued |

## Verification
On every cycle the assertions check the following properties of the grant:
- the grant is one-hot and lies inside the requests;
- any-grant matches the OR of the requests;
- a wrapped grant appears only when nothing is pending at or above the pointer, and it then picks the lowest request.

The assertions also check that the pointer steps to the index past the winner, or holds when the cycle is idle.

Some behaviour only the bench scenarios can show:
- the full rotation across long request patterns, compared with an independent model;
- the pointer value that reset leaves behind;
- that a change of the requests in mid-cycle shows on the grant before the next edge.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  // Strobes sent from the grant datapath to the pointer control
  typedef struct packed {
    logic grantValid;  // some requester won this cycle
    logic wrapUsed;    // winner came from the unmasked encoder
  } arbStrobe_t;

endpackage

// File: rtl/fixed_prio_enc.sv
module fixed_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     reqIn,
  output logic [N-1:0]     oneHot,
  output logic [IDX_W-1:0] winIdx,
  output logic             found
);

  // Lowest index wins: scan downwards so the last hit is the lowest bit
  always_comb begin
    oneHot = '0;
    winIdx = '0;
    found  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqIn[i]) begin
        oneHot    = '0;
        oneHot[i] = 1'b1;
        winIdx    = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rr_arb_datapath.sv
module rr_arb_datapath
  import rr_arb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     reqVec,
  input  logic [IDX_W-1:0] ptr,
  output logic [N-1:0]     grantVec,
  output logic [IDX_W-1:0] grantIdx,
  output logic             anyGrant,
  output arbStrobe_t       strobe
);

  logic [N-1:0]     thermoMask;
  logic [N-1:0]     maskedReq;
  logic [N-1:0]     hotMasked, hotRaw;
  logic [IDX_W-1:0] idxMasked, idxRaw;
  logic             hitMasked, hitRaw;

  // Thermometer mask: keep indices at or above the pointer
  for (genvar i = 0; i < N; i++) begin : g_thermo
    localparam logic [IDX_W-1:0] BIT_IDX = IDX_W'(i);
    assign thermoMask[i] = (BIT_IDX >= ptr);
  end

  assign maskedReq = reqVec & thermoMask;

  fixed_prio_enc #(.N(N), .IDX_W(IDX_W)) u_encMasked (
    .reqIn (maskedReq),
    .oneHot(hotMasked),
    .winIdx(idxMasked),
    .found (hitMasked)
  );

  fixed_prio_enc #(.N(N), .IDX_W(IDX_W)) u_encRaw (
    .reqIn (reqVec),
    .oneHot(hotRaw),
    .winIdx(idxRaw),
    .found (hitRaw)
  );

  always_comb begin
    if (hitMasked) begin
      grantVec = hotMasked;
      grantIdx = idxMasked;
    end else begin
      grantVec = hotRaw;
      grantIdx = idxRaw;
    end
    anyGrant          = hitMasked | hitRaw;
    strobe.grantValid = anyGrant;
    strobe.wrapUsed   = !hitMasked && hitRaw;
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec));

  // R2
  grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grantVec & ~reqVec) == '0);

  // R3
  any_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anyGrant == (|reqVec));

  // R4
  wrap_only_if_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (anyGrant && (grantIdx < ptr)) |-> ((reqVec >> ptr) == '0));

  // R5
  wrap_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (anyGrant && (grantIdx < ptr)) |-> ((reqVec & ((N'(1) << grantIdx) - N'(1))) == '0));

endmodule

// File: rtl/rr_arb_ctrl.sv
module rr_arb_ctrl
  import rr_arb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  arbStrobe_t       strobe,
  input  logic [IDX_W-1:0] grantIdx,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] nextPtr;

  // N is a power of two, so the IDX_W-bit add wraps modulo N
  assign nextPtr = grantIdx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                 ptr <= '0;
    else if (strobe.grantValid) ptr <= nextPtr;
  end

  // R6
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.grantValid |=> (ptr == IDX_W'($past(grantIdx) + IDX_W'(1))));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.grantValid |=> $stable(ptr));

  // R5
  wrap_below_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.grantValid && strobe.wrapUsed) |-> (grantIdx < ptr));

endmodule

// File: rtl/rr_thermo_arbiter.sv
module rr_thermo_arbiter
  import rr_arb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] reqVec,
  output logic [N-1:0] grantVec,
  output logic         anyGrant
);

  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] grantIdx;
  arbStrobe_t       strobe;

  rr_arb_datapath #(.N(N), .IDX_W(IDX_W)) u_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqVec  (reqVec),
    .ptr     (ptr),
    .grantVec(grantVec),
    .grantIdx(grantIdx),
    .anyGrant(anyGrant),
    .strobe  (strobe)
  );

  rr_arb_ctrl #(.N(N), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .grantIdx(grantIdx),
    .ptr     (ptr)
  );

endmodule

// File: tb/rr_thermo_arbiter_tb.sv
module rr_thermo_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int NVEC       = 16;

  localparam logic [N-1:0] REQ_TABLE [NVEC] = '{
    8'hFF, 8'hFF, 8'hFF, 8'h01, 8'h00, 8'h80, 8'h81, 8'h10,
    8'h0F, 8'hA5, 8'h00, 8'h42, 8'h24, 8'h18, 8'h80, 8'h01
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] reqVec = '0;
  logic [N-1:0] grantVec;
  logic         anyGrant;

  int  checks = 0;
  int  failures = 0;
  int  expPtr = 0;
  bit  done = 1'b0;

  rr_thermo_arbiter #(.N(N)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqVec  (reqVec),
    .grantVec(grantVec),
    .anyGrant(anyGrant)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Rotating search from the model pointer
  function automatic logic [N-1:0] modelGrant(input logic [N-1:0] r, input int p);
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (p + k) % N;
      if (r[idx]) return N'(1) << idx;
    end
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, check before the next rising edge, then clock and update the model
  task automatic step(input logic [N-1:0] req, input logic [N-1:0] expGrant, input string tag);
    @(negedge clk);
    reqVec = req;
    #1;
    chk(tag, grantVec, expGrant);
    chk("R3 any-grant", N'(anyGrant), N'(req != '0));
    @(posedge clk);
    for (int b = 0; b < N; b++) if (expGrant[b]) expPtr = (b + 1) % N;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n  = 1'b0;
    reqVec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R2 idle grant in reset", grantVec, '0);
    rst_n  = 1'b1;
    expPtr = 0;
  endtask

  initial begin
    doReset();

    // R1: pointer at 0 -> lowest active request wins
    step(8'hAC, 8'h04, "R1 first grant after reset");
    // R4: pointer 3 -> index 3
    step(8'h0C, 8'h08, "R4 at-or-above pointer");
    // R7: idle cycles keep pointer at 4
    step(8'h00, 8'h00, "R7 idle 1");
    step(8'h00, 8'h00, "R7 idle 2");
    step(8'h00, 8'h00, "R2 no request no grant");
    step(8'h11, 8'h10, "R7 pointer held over idle");
    // R5: pointer 5, nothing above -> lowest
    step(8'h03, 8'h01, "R5 wrap to lowest");
    // R6: grant at N-1 wraps pointer to 0
    step(8'h80, 8'h80, "R6 grant top index");
    step(8'h81, 8'h01, "R6 pointer wrapped to 0");

    // R8: mid-cycle request change visible before the edge (pointer 1)
    @(negedge clk);
    reqVec = 8'h02;
    #1;
    chk("R8 grant follows request", grantVec, 8'h02);
    reqVec = 8'h04;
    #2;
    chk("R8 grant follows mid-cycle change", grantVec, 8'h04);
    @(posedge clk);
    expPtr = 3;

    // Table walk against the model
    for (int v = 0; v < NVEC; v++) begin
      step(REQ_TABLE[v], modelGrant(REQ_TABLE[v], expPtr), "R4 R5 R6 table");
    end

    // R1: reset in mid-run returns pointer to 0
    step(8'h40, 8'h40, "R6 setup");
    doReset();
    step(8'h81, 8'h01, "R1 pointer cleared by reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule